// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words and reports whether the first is greater than, equal to, or less than the second. It is built from identical 4-bit slices. Each slice compares its own bit pairs, starting at its top bit. Only when all of its pairs match does the slice take its result from three expansion inputs, which carry the verdict of the less significant slice below it.

The top module chains a parameterised number of slices in series, so it compares words whose width is a multiple of four. Slice 0 receives the tie-in constant internally: greater low, equal high, less low. Every slice passes its three outputs up to the expansion inputs of the slice above it. The top slice drives the final result.

The block has no clock and no registers. The inputs are treated purely as weighted unsigned bits, so any monotonic code, such as BCD, compares correctly.

Top module: `mag_chain`

## Requirements
- R1: In a slice, the highest bit position where A and B differ decides the result. If A holds the 1 there, the outputs are greater=1, equal=0, less=0. If B holds the 1, the outputs are less=1, greater=0, equal=0. The expansion inputs have no effect in either case.
- R2: When every bit pair of a slice matches and the equal expansion input is 1, the slice drives equal=1 and greater=less=0, whatever the other two expansion inputs are.
- R3: On a full tie with the equal expansion input at 0, the greater expansion input at 1 and the less expansion input at 0, the slice drives greater=1 only. The mirror case, with only the less expansion input at 1, drives less=1 only.
- R4: On a full tie with the equal expansion input at 0 and both the greater and less expansion inputs at 1, all three slice outputs are 0.
- R5: On a full tie with all three expansion inputs at 0, the slice drives greater=1 and less=1, with equal=0.
- R6: The chain feeds each slice's greater/equal/less outputs into the matching expansion inputs of the next more significant slice. Slice 0 is fed greater=0, equal=1, less=0.
- R7: For any operands, the top outputs equal the native unsigned comparison of the full words: greater is (A>B), equal is (A==B), less is (A<B). Exactly one output is 1.
- R8: The parameter SLICES (default 3) sets the operand width to 4*SLICES bits. A value below 1 is rejected at elaboration. With SLICES=1, the chain behaves as a single slice with the tie-in constant applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_word | input | 4*SLICES | Operand A, unsigned, bit 0 least significant |
| b_word | input | 4*SLICES | Operand B, unsigned, bit 0 least significant |
| a_gt | output | 1 | 1 when A is greater than B |
| a_eq | output | 1 | 1 when A equals B |
| a_lt | output | 1 | 1 when A is less than B |

## Verification
The block holds no state, so a fault shows at the ports as soon as the inputs settle, with no delay in cycles.

- A fault in a slice's bit-pair priority shows as a wrong verdict for operand pairs that first differ at the affected position.
- A fault in the tie resolver shows only on full ties, under particular expansion-input combinations.
- A fault in the chain wiring or the slice-0 constant shows as a wrong verdict when the upper slices tie.

The exhaustive sweep of a standalone slice covers every operand pair and every expansion combination. The directed and random chain tests cover the wiring between slices.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

   localparam int unsigned SLICE_W = 4;

   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } cmp_res_t;

   localparam cmp_res_t CHAIN_SEED = cmp_res_t'{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/cmp_pair_prio.sv
module cmp_pair_prio #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         a_wins,
   output logic         b_wins,
   output logic         full_tie
);
   if (W < 1) begin : g_bad_w
      $error("cmp_pair_prio: W must be at least 1");
   end

   logic [W:0]   eq_above;
   logic [W-1:0] win_a;
   logic [W-1:0] win_b;

   assign eq_above[W] = 1'b1;

   for (genvar i = W - 1; i >= 0; i--) begin : g_pair
      assign eq_above[i] = eq_above[i+1] & ~(a[i] ^ b[i]);
      assign win_a[i]    = eq_above[i+1] &  a[i] & ~b[i];
      assign win_b[i]    = eq_above[i+1] & ~a[i] &  b[i];
   end

   assign a_wins   = |win_a;
   assign b_wins   = |win_b;
   assign full_tie = eq_above[0];

   always_comb begin
      a_r1_prio_exclusive: assert ($countones({a_wins, b_wins, full_tie}) == 1)
         else $error("priority outcomes not exclusive");
   end
endmodule

// File: rtl/cmp_tie_resolve.sv
module cmp_tie_resolve
   import mag_cmp_pkg::*;
(
   input  cmp_res_t exp_in,
   output cmp_res_t tie_res
);
   always_comb begin
      if (exp_in.eq) begin
         tie_res = cmp_res_t'{gt: 1'b0, eq: 1'b1, lt: 1'b0};
      end else begin
         tie_res.gt = ~exp_in.lt;
         tie_res.eq = 1'b0;
         tie_res.lt = ~exp_in.gt;
      end
   end

   always_comb begin
      if (!exp_in.eq && (exp_in.gt ^ exp_in.lt))
         a_r3_single_passes: assert (tie_res == exp_in)
            else $error("single expansion flag not passed through");
      if (!exp_in.eq && exp_in.gt && exp_in.lt)
         a_r4_both_high_null: assert (tie_res == 3'b000)
            else $error("both expansion flags should give all zero");
   end
endmodule

// File: rtl/mag_slice.sv
module mag_slice
   import mag_cmp_pkg::*;
#(
   parameter int unsigned W = SLICE_W
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  cmp_res_t     exp_in,
   output cmp_res_t     res
);
   logic     a_wins, b_wins, full_tie;
   cmp_res_t tie_res;

   cmp_pair_prio #(.W(W)) u_prio (
      .a        (a),
      .b        (b),
      .a_wins   (a_wins),
      .b_wins   (b_wins),
      .full_tie (full_tie)
   );

   cmp_tie_resolve u_tie (
      .exp_in  (exp_in),
      .tie_res (tie_res)
   );

   always_comb begin
      if (a_wins)      res = cmp_res_t'{gt: 1'b1, eq: 1'b0, lt: 1'b0};
      else if (b_wins) res = cmp_res_t'{gt: 1'b0, eq: 1'b0, lt: 1'b1};
      else             res = tie_res;
   end

   always_comb begin
      if (a != b)
         a_r1_first_diff: assert (res.gt == (a > b) && res.lt == (a < b) && !res.eq)
            else $error("unequal operands misjudged");
      if (a == b && exp_in.eq)
         a_r2_tie_eq: assert (res == 3'b010)
            else $error("tie with equal expansion not equal");
      if (a == b && exp_in == 3'b000)
         a_r5_all_low: assert (res == 3'b101)
            else $error("all-low expansion should give gt and lt");
   end
endmodule

// File: rtl/mag_chain.sv
module mag_chain
   import mag_cmp_pkg::*;
#(
   parameter int unsigned SLICES = 3,
   localparam int unsigned WIDTH = SLICES * SLICE_W
) (
   input  logic [WIDTH-1:0] a_word,
   input  logic [WIDTH-1:0] b_word,
   output logic             a_gt,
   output logic             a_eq,
   output logic             a_lt
);
   if (SLICES < 1) begin : g_bad_slices
      $error("mag_chain: SLICES must be at least 1");
   end

   cmp_res_t link [SLICES+1];

   assign link[0] = CHAIN_SEED;

   for (genvar k = 0; k < SLICES; k++) begin : g_slice
      mag_slice #(.W(SLICE_W)) u_slice (
         .a      (a_word[k*SLICE_W +: SLICE_W]),
         .b      (b_word[k*SLICE_W +: SLICE_W]),
         .exp_in (link[k]),
         .res    (link[k+1])
      );
   end

   assign a_gt = link[SLICES].gt;
   assign a_eq = link[SLICES].eq;
   assign a_lt = link[SLICES].lt;

   always_comb begin
      a_r7_native_match: assert (a_gt == (a_word > b_word) && a_eq == (a_word == b_word)
                                 && a_lt == (a_word < b_word))
         else $error("chain result differs from unsigned compare");
      a_r6_onehot: assert ($onehot0({a_gt, a_eq, a_lt}) && (a_gt | a_eq | a_lt))
         else $error("chain result not one-hot");
   end
endmodule

// File: tb/tb_mag_chain.sv
module tb_mag_chain;
   import mag_cmp_pkg::*;

   localparam int unsigned N = 3;
   localparam int unsigned WD = N * 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [WD-1:0] a_word, b_word;
   logic a_gt, a_eq, a_lt;

   mag_chain #(.SLICES(N)) dut (
      .a_word(a_word), .b_word(b_word), .a_gt(a_gt), .a_eq(a_eq), .a_lt(a_lt)
   );

   logic [3:0] a1, b1;
   logic o1_gt, o1_eq, o1_lt;
   mag_chain #(.SLICES(1)) dut1 (
      .a_word(a1), .b_word(b1), .a_gt(o1_gt), .a_eq(o1_eq), .a_lt(o1_lt)
   );

   logic [3:0] sa, sb;
   cmp_res_t   sx, sres;
   mag_slice u_slice (.a(sa), .b(sb), .exp_in(sx), .res(sres));

   function automatic logic [2:0] ref_slice(input logic [3:0] a, input logic [3:0] b,
                                             input logic [2:0] x);
      if (a > b) return 3'b100;
      if (a < b) return 3'b001;
      case (x)
         3'b010, 3'b110, 3'b011, 3'b111: return 3'b010;
         3'b100: return 3'b100;
         3'b001: return 3'b001;
         3'b101: return 3'b000;
         default: return 3'b101;
      endcase
   endfunction

   task automatic check3(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic chain_case(input logic [WD-1:0] a, input logic [WD-1:0] b, input string req);
      a_word = a; b_word = b;
      #2;
      check3(req, {a_gt, a_eq, a_lt}, {a > b, a == b, a < b});
   endtask

   task automatic t_idle_equal;
      chain_case('0, '0, "R7 zero operands equal");
   endtask

   task automatic t_slice_sweep;
      for (int i = 0; i < 256; i++) begin
         for (int x = 0; x < 8; x++) begin
            string req;
            sa = i[7:4]; sb = i[3:0]; sx = x[2:0];
            #1;
            if (sa != sb)              req = "R1 first differing pair";
            else if (x[1])             req = "R2 tie equal expansion";
            else if (x == 4 || x == 1) req = "R3 single expansion flag";
            else if (x == 5)           req = "R4 both flags high";
            else                       req = "R5 all flags low";
            check3(req, sres, ref_slice(sa, sb, x[2:0]));
         end
      end
   endtask

   task automatic t_chain_directed;
      chain_case(12'hFFF, 12'h000, "R7 max vs zero");
      chain_case(12'h000, 12'hFFF, "R7 zero vs max");
      chain_case(12'h801, 12'h7FF, "R1 top bit decides");
      chain_case(12'hA50, 12'hA51, "R6 tie ripples from slice 0");
      chain_case(12'h5A3, 12'h5A3, "R6 seed gives equal");
      chain_case(12'h3C0, 12'h3B9, "R6 middle slice decides");
      chain_case(12'h999, 12'h998, "R7 BCD-like codes");
   endtask

   task automatic t_chain_random;
      for (int k = 0; k < 400; k++) begin
         logic [WD-1:0] ra, rb;
         ra = WD'($urandom);
         rb = (k % 4 == 0) ? ra ^ WD'(1 << (k % WD)) : WD'($urandom);
         chain_case(ra, rb, "R7 random operands");
      end
   endtask

   task automatic t_single_slice;
      for (int i = 0; i < 256; i++) begin
         a1 = i[7:4]; b1 = i[3:0];
         #1;
         check3("R8 single-slice chain", {o1_gt, o1_eq, o1_lt}, {a1 > b1, a1 == b1, a1 < b1});
      end
   endtask

   initial begin
      a_word = '0; b_word = '0; a1 = '0; b1 = '0;
      sa = '0; sb = '0; sx = CHAIN_SEED;
      #3;
      t_idle_equal();
      t_slice_sweep();
      t_chain_directed();
      t_chain_random();
      t_single_slice();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule